// File: doc/BRIEF.md
# AES Round-Key Schedule Generator with Borrowed Substitution Port

This block turns a 128-bit or 256-bit cipher key into every AES round key and keeps them all in registers. A block-processing datapath then reads whichever round key it needs by index. The block has no S-box of its own. Each key-schedule word is substituted through the four-byte word S-box that belongs to the encipher datapath. The block asks for that port with a request line and moves forward only on cycles in which a grant is given. As a result, key expansion and block encryption cannot overlap.

A user applies the key and the length select, then pulses the start input for one cycle. The ready output falls on the next edge. After that the block computes one 32-bit schedule word per granted clock. Ready rises again once the final word is stored. From then on the round keys can be read combinationally by index.

Top module: `keyexp_top`

## Requirements
- R1: The key length is chosen by `keyLen256` (0 selects 128-bit, 1 selects 256-bit). It is sampled when a start pulse is accepted. Key word 0 is `cipherKey[255:224]`, and the following words continue toward the LSBs. A 128-bit key uses only `cipherKey[255:128]`.
- R2: A start pulse is accepted only while `ready` is 1. After an accepted pulse, `ready` is 0 from the next edge onward. `ready` returns to 1 on the edge that stores the last schedule word. With the grant held high, that edge is 40 edges after the start edge for a 128-bit key and 52 edges after it for a 256-bit key.
- R3: Word i is word i−Nk XORed with a temp value. When i mod Nk is 0, temp is the substitution of the previous word rotated left by one byte, XORed with the round constant in the top byte. Otherwise temp is simply the previous word. The round constants run 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R4: For a 256-bit key, when i mod 8 is 4, temp is the substitution of the previous word, with no rotation and no round constant.
- R5: `sboxReq` is 1 exactly while expansion runs. `toSbox` carries the word to be substituted, and `fromSbox` returns its byte-wise substitution in the same cycle. A cycle with `sboxGrant` at 0 stores nothing and delays completion by one edge.
- R6: `roundKey` is {w[4k], w[4k+1], w[4k+2], w[4k+3]} for `rkIndex` = k, with w[4k] in bits 127:96. This gives 11 keys (k = 0..10) for a 128-bit key and 15 keys (k = 0..14) for a 256-bit key. Index 15 reads zero.
- R7: A start pulse that arrives while expansion is running has no effect. It changes neither the completion time, the key length nor the stored keys.
- R8: After reset, `ready` is 1, `sboxReq` is 0 and every round key reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cipherKey | input | 256 | Cipher key, word 0 in the MSBs |
| keyLen256 | input | 1 | 1 selects a 256-bit key, 0 selects a 128-bit key |
| initPulse | input | 1 | Starts expansion when ready |
| ready | output | 1 | High when idle with the round keys valid |
| rkIndex | input | 4 | Round-key index |
| roundKey | output | 128 | Selected round key |
| sboxReq | output | 1 | Requests the shared word substitution port |
| sboxGrant | input | 1 | Port granted for this cycle |
| toSbox | output | 32 | Word sent for substitution |
| fromSbox | input | 32 | Substituted word returned |

## Verification
The hardest situation to reach is a schedule step that must wait on a withdrawn grant, or that sees a competing start pulse, in the middle of a substitution cycle. From outside, the block looks only as if it finished later. The bench models the shared S-box as a computed lookup and drives the grant low for a chosen window of edges. It also injects a second start pulse, with a different key and length, partway through expansion. The completion edge is then compared with the count derived from the requirements, and every stored round key is compared with a reference schedule and with published key-expansion example values.

// File: rtl/keyexp_pkg.sv
`timescale 1ns/1ps
package keyexp_pkg;
  localparam int WORD_W    = 32;
  localparam int NK128     = 4;
  localparam int NK256     = 8;
  localparam int KEY_W     = NK256 * WORD_W;
  localparam int MAX_WORDS = 4 * (NK256 + 7);
  localparam int LAST128_I = 4 * (NK128 + 7) - 1;
  localparam int LAST256_I = MAX_WORDS - 1;
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam int RK_IDX_W  = IDX_W - 2;
  localparam int MAX_RK    = NK256 + 7;
  localparam int RK_W      = 4 * WORD_W;

  typedef struct packed {
    logic             load;
    logic             wr;
    logic             rot;
    logic             sub;
    logic             len256;
    logic [7:0]       rcon;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/keyexp_ctrl.sv
`timescale 1ns/1ps
module keyexp_ctrl
  import keyexp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    initPulse,
  input  logic    keyLen256,
  input  logic    sboxGrant,
  output logic    ready,
  output logic    sboxReq,
  output strobe_t st
);
  localparam logic [IDX_W-1:0] FIRST128 = IDX_W'(NK128);
  localparam logic [IDX_W-1:0] FIRST256 = IDX_W'(NK256);
  localparam logic [IDX_W-1:0] LAST128  = IDX_W'(LAST128_I);
  localparam logic [IDX_W-1:0] LAST256  = IDX_W'(LAST256_I);

  logic             busy;
  logic             len256Reg;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] firstIdx;
  logic [7:0]       rcon;
  logic             atRot;
  logic             atSubOnly;
  logic             stepping;
  logic             accept;

  always_comb begin
    lastIdx   = len256Reg ? LAST256 : LAST128;
    firstIdx  = len256Reg ? FIRST256 : FIRST128;
    atRot     = len256Reg ? (idx[2:0] == 3'd0) : (idx[1:0] == 2'd0);
    atSubOnly = len256Reg && (idx[2:0] == 3'd4);
    stepping  = busy && sboxGrant;
    accept    = initPulse && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      len256Reg <= 1'b0;
      idx       <= '0;
      rcon      <= 8'h01;
    end else if (accept) begin
      busy      <= 1'b1;
      len256Reg <= keyLen256;
      idx       <= keyLen256 ? FIRST256 : FIRST128;
      rcon      <= 8'h01;
    end else if (stepping) begin
      idx <= idx + IDX_W'(1);
      if (atRot) rcon <= {rcon[6:0], 1'b0} ^ (rcon[7] ? 8'h1B : 8'h00);
      if (idx == lastIdx) busy <= 1'b0;
    end
  end

  always_comb begin
    ready     = !busy;
    sboxReq   = busy;
    st.load   = accept;
    st.wr     = stepping;
    st.rot    = atRot;
    st.sub    = atRot || atSubOnly;
    st.len256 = len256Reg;
    st.rcon   = rcon;
    st.idx    = idx;
  end

  assert_init_drops_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (initPulse && ready) |=> !ready);

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sboxGrant) |=> (busy && $stable(idx)));

  assert_init_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && initPulse && sboxGrant && idx != lastIdx) |=>
      (idx == $past(idx) + IDX_W'(1) && $stable(len256Reg)));

  assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (idx >= firstIdx && idx <= lastIdx));
endmodule

// File: rtl/keyexp_dp.sv
`timescale 1ns/1ps
module keyexp_dp
  import keyexp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic [KEY_W-1:0]    cipherKey,
  input  logic [WORD_W-1:0]   fromSbox,
  input  logic [RK_IDX_W-1:0] rkIndex,
  output logic [WORD_W-1:0]   toSbox,
  output logic [RK_W-1:0]     roundKey
);
  logic [WORD_W-1:0] words [MAX_WORDS];
  logic [WORD_W-1:0] prevWord;
  logic [WORD_W-1:0] backWord;
  logic [WORD_W-1:0] newWord;
  logic [WORD_W-1:0] rconWord;
  logic [IDX_W-1:0]  base;

  always_comb begin
    prevWord = words[st.idx - IDX_W'(1)];
    backWord = st.len256 ? words[st.idx - IDX_W'(NK256)]
                         : words[st.idx - IDX_W'(NK128)];
    toSbox   = st.rot ? {prevWord[WORD_W-9:0], prevWord[WORD_W-1 -: 8]} : prevWord;
    rconWord = st.rot ? {st.rcon, {(WORD_W-8){1'b0}}} : '0;
    newWord  = st.sub ? (backWord ^ fromSbox ^ rconWord) : (backWord ^ prevWord);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < MAX_WORDS; j++) words[j] <= '0;
    end else if (st.load) begin
      for (int j = 0; j < NK256; j++)
        words[j] <= cipherKey[KEY_W-1-WORD_W*j -: WORD_W];
    end else if (st.wr) begin
      words[st.idx] <= newWord;
    end
  end

  always_comb begin
    base = IDX_W'({rkIndex, 2'b00});
    if (rkIndex < RK_IDX_W'(MAX_RK))
      roundKey = {words[base], words[base + IDX_W'(1)],
                  words[base + IDX_W'(2)], words[base + IDX_W'(3)]};
    else
      roundKey = '0;
  end

  assert_load_write_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.load |-> !st.wr);
endmodule

// File: rtl/keyexp_top.sv
`timescale 1ns/1ps
module keyexp_top
  import keyexp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [KEY_W-1:0]    cipherKey,
  input  logic                keyLen256,
  input  logic                initPulse,
  output logic                ready,
  input  logic [RK_IDX_W-1:0] rkIndex,
  output logic [RK_W-1:0]     roundKey,
  output logic                sboxReq,
  input  logic                sboxGrant,
  output logic [WORD_W-1:0]   toSbox,
  input  logic [WORD_W-1:0]   fromSbox
);
  strobe_t st;

  keyexp_ctrl ctrl (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .keyLen256(keyLen256),
    .sboxGrant(sboxGrant), .ready(ready), .sboxReq(sboxReq), .st(st)
  );

  keyexp_dp dp (
    .clk(clk), .rstN(rstN), .st(st), .cipherKey(cipherKey), .fromSbox(fromSbox),
    .rkIndex(rkIndex), .toSbox(toSbox), .roundKey(roundKey)
  );
endmodule

// File: tb/keyexp_top_test.sv
`timescale 1ns/1ps
module keyexp_top_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [255:0] cipherKey = '0;
  logic         keyLen256 = 1'b0;
  logic         initPulse = 1'b0;
  logic         ready;
  logic [3:0]   rkIndex = '0;
  logic [127:0] roundKey;
  logic         sboxReq;
  logic         sboxGrant = 1'b1;
  logic [31:0]  toSbox;
  logic [31:0]  fromSbox;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0]  sbTab [256];
  logic [31:0] refW [60];

  always #10 clk = ~clk;

  keyexp_top uut (
    .clk(clk), .rstN(rstN), .cipherKey(cipherKey), .keyLen256(keyLen256),
    .initPulse(initPulse), .ready(ready), .rkIndex(rkIndex), .roundKey(roundKey),
    .sboxReq(sboxReq), .sboxGrant(sboxGrant), .toSbox(toSbox), .fromSbox(fromSbox)
  );

  always_comb fromSbox = {sbTab[toSbox[31:24]], sbTab[toSbox[23:16]],
                          sbTab[toSbox[15:8]], sbTab[toSbox[7:0]]};

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic buildSbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      for (int b = 1; b < 256; b++)
        if (gmul(8'(x), 8'(b)) == 8'h01) inv = 8'(b);
      sbTab[x] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    end
  endtask

  function automatic logic [31:0] subW(input logic [31:0] w);
    return {sbTab[w[31:24]], sbTab[w[23:16]], sbTab[w[15:8]], sbTab[w[7:0]]};
  endfunction

  task automatic refExpand(input logic [255:0] key, input bit is256);
    int nk = is256 ? 8 : 4;
    int total = is256 ? 60 : 44;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < nk; i++) refW[i] = key[255 - 32*i -: 32];
    for (int i = nk; i < total; i++) begin
      logic [31:0] t = refW[i-1];
      if (i % nk == 0) begin
        t = subW({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1B : 8'h00);
      end else if (is256 && (i % 8 == 4)) begin
        t = subW(t);
      end
      refW[i] = refW[i-nk] ^ t;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readKey(input int k, output logic [127:0] v);
    @(negedge clk);
    rkIndex = 4'(k);
    #1 v = roundKey;
  endtask

  task automatic doReset();
    rstN = 1'b0; initPulse = 1'b0; sboxGrant = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Starts expansion and returns the edge count from the start edge to completion.
  task automatic runExpand(input logic [255:0] key, input bit is256, input int stallFrom,
                           input int stallLen, input int injectAt, output int n);
    @(negedge clk);
    cipherKey = key; keyLen256 = is256; initPulse = 1'b1; sboxGrant = 1'b1;
    @(posedge clk);
    @(negedge clk);
    initPulse = 1'b0;
    check(ready == 1'b0, "R2 ready low after start", 128'(ready), 128'(0));
    check(sboxReq == 1'b1, "R5 request while running", 128'(sboxReq), 128'(1));
    n = 0;
    while (n < 300) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (ready) break;
      sboxGrant = !((n + 1 > stallFrom) && (n + 1 <= stallFrom + stallLen));
      initPulse = (n == injectAt);
      if (n == injectAt) begin
        keyLen256 = ~is256;
        cipherKey = ~key;
      end
    end
    initPulse = 1'b0; sboxGrant = 1'b1;
    check(sboxReq == 1'b0, "R5 request drops when done", 128'(sboxReq), 128'(0));
  endtask

  task automatic compareAll(input logic [255:0] key, input bit is256, input string tag);
    logic [127:0] v;
    int nrk = is256 ? 15 : 11;
    refExpand(key, is256);
    for (int k = 0; k < nrk; k++) begin
      logic [127:0] e = {refW[4*k], refW[4*k+1], refW[4*k+2], refW[4*k+3]};
      readKey(k, v);
      check(v === e, tag, v, e);
    end
  endtask

  task automatic testReset();
    logic [127:0] v;
    doReset();
    check(ready == 1'b1, "R8 ready after reset", 128'(ready), 128'(1));
    check(sboxReq == 1'b0, "R8 no request after reset", 128'(sboxReq), 128'(0));
    readKey(0, v);
    check(v === '0, "R8 key 0 zero after reset", v, '0);
    readKey(14, v);
    check(v === '0, "R8 key 14 zero after reset", v, '0);
  endtask

  task automatic testFips128();
    logic [255:0] key = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    logic [127:0] v;
    int n;
    runExpand(key, 1'b0, 1000, 0, -1, n);
    check(n == 40, "R2 128-bit completion edge", 128'(n), 128'(40));
    readKey(0, v);
    check(v === 128'h2b7e151628aed2a6abf7158809cf4f3c, "R1 key 0 is cipher key", v, 128'h2b7e151628aed2a6abf7158809cf4f3c);
    readKey(1, v);
    check(v === 128'ha0fafe1788542cb123a339392a6c7605, "R3 round key 1", v, 128'ha0fafe1788542cb123a339392a6c7605);
    readKey(10, v);
    check(v === 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R3 round key 10", v, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    compareAll(key, 1'b0, "R6 128-bit schedule");
  endtask

  task automatic testFips256();
    logic [255:0] key = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    logic [127:0] v;
    int n;
    runExpand(key, 1'b1, 1000, 0, -1, n);
    check(n == 52, "R2 256-bit completion edge", 128'(n), 128'(52));
    readKey(1, v);
    check(v === 128'h1f352c073b6108d72d9810a30914dff4, "R1 256-bit key low half", v, 128'h1f352c073b6108d72d9810a30914dff4);
    readKey(2, v);
    check(v === 128'h9ba354118e6925afa51a8b5f2067fcde, "R3 256-bit round key 2", v, 128'h9ba354118e6925afa51a8b5f2067fcde);
    readKey(3, v);
    check(v[127:96] === 32'ha8b09c1a, "R4 sub-only word 12", 128'(v[127:96]), 128'(32'ha8b09c1a));
    readKey(14, v);
    check(v === 128'hfe4890d1e6188d0b046df344706c631e, "R3 256-bit round key 14", v, 128'hfe4890d1e6188d0b046df344706c631e);
    compareAll(key, 1'b1, "R4 256-bit schedule");
    readKey(15, v);
    check(v === '0, "R6 index 15 reads zero", v, '0);
  endtask

  task automatic testStall();
    logic [255:0] key = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    int n;
    runExpand(key, 1'b1, 6, 20, -1, n);
    check(n == 72, "R5 stall delays 256-bit completion", 128'(n), 128'(72));
    compareAll(key, 1'b1, "R5 keys after stall");
    runExpand(key, 1'b0, 3, 5, -1, n);
    check(n == 45, "R5 stall delays 128-bit completion", 128'(n), 128'(45));
    compareAll(key, 1'b0, "R5 128-bit keys after stall");
  endtask

  task automatic testInitIgnored();
    logic [255:0] key = {128'hffeeddccbbaa99887766554433221100, 128'h0123456789abcdef0123456789abcdef};
    int n;
    runExpand(key, 1'b0, 1000, 0, 10, n);
    check(n == 40, "R7 busy start pulse ignored (timing)", 128'(n), 128'(40));
    compareAll(key, 1'b0, "R7 busy start pulse ignored (keys)");
  endtask

  task automatic testPatterns();
    int n;
    runExpand('0, 1'b0, 1000, 0, -1, n);
    compareAll('0, 1'b0, "R3 all-zero 128-bit key");
    runExpand('1, 1'b1, 1000, 0, -1, n);
    compareAll('1, 1'b1, "R4 all-ones 256-bit key");
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=%0t expected=done", $time);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    buildSbox();
    testReset();
    testFips128();
    testFips256();
    testStall();
    testInitIgnored();
    testPatterns();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule